// File: doc/BRIEF.md
# Two-Slot ALU Reservation Station with Two-Cycle Executor

This block sits between an instruction dispatcher and the result broadcast bus of a small out-of-order core. The dispatcher hands it one integer operation per cycle: an opcode, two source operands and a destination reorder-buffer tag. Each source arrives either as a ready value or as the tag of the instruction that will produce it. The block parks the operation in one of two slots. While a source is missing, the slot watches both the external broadcast bus and the block's own result port, and copies in the value when the tag matches.

Each cycle, one slot whose two sources are both present is picked. The pick goes by readiness and not by age, so a younger ready operation overtakes an older stalled one. The picked operation moves through a two-stage ALU, and the result leaves with its destination tag as a one-cycle pulse. A slot becomes free in the cycle its operation enters the ALU. The full flag tells the dispatcher to hold off.

Top module: `alu_issue_unit`

## Requirements
- R1: While reset (active-low `rstN`) is applied, and in the first cycle after it is released, `rsFull` and `resValid` are low.
- R2: Opcodes are decoded on 8-bit data as 3'b000 add, 3'b001 subtract (A minus B), 3'b010 and, 3'b011 or, 3'b100 xor. Add and subtract wrap modulo 256 and produce no flags.
- R3: An operation dispatched with both sources ready drives `resValid` high, with its destination tag and value, in the third cycle after its dispatch cycle. `resValid` stays high for exactly one cycle per operation.
- R4: A parked source that is not ready captures `extValue` in any cycle where `extValid` is high and `extTag` equals its tag. With the other source ready, the result appears in the third cycle after that broadcast cycle.
- R5: A parked source also captures the block's own result when `resValid` is high and `resTag` matches. The dependent result follows three cycles after its producer's result.
- R6: A source that is not ready at dispatch, but whose tag matches a broadcast in that same dispatch cycle, is captured at dispatch. The operation then issues as if the source had been ready.
- R7: `rsFull` is high exactly when both slots hold an operation. A dispatch offered while `rsFull` is high is ignored and never produces a result.
- R8: A ready operation issues ahead of an older operation that is still waiting for a source.
- R9: A dispatch fills the lowest-numbered free slot. When both slots become ready in the same cycle, the lower-numbered slot issues first.
- R10: At most one operation enters the ALU per cycle, so results are spaced at least one cycle apart. Two operations ready together produce results in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dispValid | input | 1 | Dispatch offer this cycle |
| dispOp | input | 3 | Opcode of the offered operation |
| dispAReady | input | 1 | Source A carries a value |
| dispATag | input | 2 | Producer tag of source A when not ready |
| dispAValue | input | 8 | Value of source A when ready |
| dispBReady | input | 1 | Source B carries a value |
| dispBTag | input | 2 | Producer tag of source B when not ready |
| dispBValue | input | 8 | Value of source B when ready |
| dispDstTag | input | 2 | Destination reorder-buffer tag |
| rsFull | output | 1 | Both slots occupied; dispatch is ignored |
| extValid | input | 1 | External broadcast valid |
| extTag | input | 2 | External broadcast tag |
| extValue | input | 8 | External broadcast value |
| resValid | output | 1 | Result pulse |
| resTag | output | 2 | Destination tag of the result |
| resValue | output | 8 | Result value |

## Verification
A ready dispatch is due on the result port at the third falling edge after the edge where it was driven. A broadcast wakes its consumer and is followed by the result at the third falling edge, and a result feeding a parked consumer is followed by the dependent result three edges later. `rsFull` reflects a dispatch one edge after it is driven. The bench drives inputs and samples outputs only on falling edges. Its directed checks wait exactly those edge counts and also check for silence on the cycles just before and after each result. A behavioural model of slots and pipeline, updated on every rising edge, is compared with `rsFull` and the result port on every falling edge, including through a random stream.

// File: rtl/alu_rs_pkg.sv
package alu_rs_pkg;

  localparam int DATA_W   = 8;
  localparam int TAG_W    = 2;
  localparam int OP_W     = 3;
  localparam int RS_DEPTH = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100
  } aluOpE;

  typedef struct packed {
    logic [DATA_W-1:0] value;
    logic [TAG_W-1:0]  tag;
    logic              ready;
  } operandT;

  typedef struct packed {
    logic [RS_DEPTH-1:0] alloc;
    logic [RS_DEPTH-1:0] issue;
    logic                fire;
    logic                resLive;
  } rsStrobesT;

  function automatic logic [DATA_W-1:0] aluCompute(
    input aluOpE op, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] r;
    case (op)
      OP_ADD:  r = a + b;
      OP_SUB:  r = a - b;
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic operandT wakeOperand(
    input operandT cur,
    input logic ownValid, input logic [TAG_W-1:0] ownTag, input logic [DATA_W-1:0] ownValue,
    input logic extValid, input logic [TAG_W-1:0] extTag, input logic [DATA_W-1:0] extValue);
    operandT n;
    n = cur;
    if (!cur.ready) begin
      if (ownValid && ownTag == cur.tag) begin
        n.value = ownValue;
        n.ready = 1'b1;
      end else if (extValid && extTag == cur.tag) begin
        n.value = extValue;
        n.ready = 1'b1;
      end
    end
    return n;
  endfunction

  function automatic logic [RS_DEPTH-1:0] lowestSet(input logic [RS_DEPTH-1:0] v);
    logic [RS_DEPTH-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = 0; i < RS_DEPTH; i++) begin
      if (v[i] && !found) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/alu_rs_ctrl.sv
module alu_rs_ctrl
  import alu_rs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                dispValid,
  input  logic [RS_DEPTH-1:0] opsReady,
  output rsStrobesT           strb,
  output logic                rsFull,
  output logic                resValid
);

  logic [RS_DEPTH-1:0] slotValid;
  logic [RS_DEPTH-1:0] readyVec;
  logic [RS_DEPTH-1:0] issueVec;
  logic [RS_DEPTH-1:0] allocVec;
  logic                stage1Valid;
  logic                fullNow;

  assign fullNow  = &slotValid;
  assign readyVec = slotValid & opsReady;
  assign issueVec = lowestSet(readyVec);
  assign allocVec = (dispValid && !fullNow) ? lowestSet(~slotValid) : '0;

  always_comb begin
    strb.alloc   = allocVec;
    strb.issue   = issueVec;
    strb.fire    = |issueVec;
    strb.resLive = resValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid   <= '0;
      stage1Valid <= 1'b0;
      resValid    <= 1'b0;
    end else begin
      slotValid   <= (slotValid & ~issueVec) | allocVec;
      stage1Valid <= |issueVec;
      resValid    <= stage1Valid;
    end
  end

  assign rsFull = fullNow;

endmodule

// File: rtl/alu_rs_datapath.sv
module alu_rs_datapath
  import alu_rs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  rsStrobesT           strb,
  input  logic [OP_W-1:0]     dispOp,
  input  operandT             dispA,
  input  operandT             dispB,
  input  logic [TAG_W-1:0]    dispDstTag,
  input  logic                extValid,
  input  logic [TAG_W-1:0]    extTag,
  input  logic [DATA_W-1:0]   extValue,
  output logic [RS_DEPTH-1:0] opsReady,
  output logic [TAG_W-1:0]    resTag,
  output logic [DATA_W-1:0]   resValue
);

  operandT          srcA   [RS_DEPTH];
  operandT          srcB   [RS_DEPTH];
  aluOpE            slotOp [RS_DEPTH];
  logic [TAG_W-1:0] slotDst[RS_DEPTH];

  operandT dispAWoken;
  operandT dispBWoken;

  assign dispAWoken = wakeOperand(dispA, strb.resLive, resTag, resValue,
                                  extValid, extTag, extValue);
  assign dispBWoken = wakeOperand(dispB, strb.resLive, resTag, resValue,
                                  extValid, extTag, extValue);

  for (genvar i = 0; i < RS_DEPTH; i++) begin : g_slot
    operandT nextA;
    operandT nextB;

    assign nextA = wakeOperand(srcA[i], strb.resLive, resTag, resValue,
                               extValid, extTag, extValue);
    assign nextB = wakeOperand(srcB[i], strb.resLive, resTag, resValue,
                               extValid, extTag, extValue);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        srcA[i]    <= '0;
        srcB[i]    <= '0;
        slotOp[i]  <= OP_ADD;
        slotDst[i] <= '0;
      end else if (strb.alloc[i]) begin
        srcA[i]    <= dispAWoken;
        srcB[i]    <= dispBWoken;
        slotOp[i]  <= aluOpE'(dispOp);
        slotDst[i] <= dispDstTag;
      end else begin
        srcA[i] <= nextA;
        srcB[i] <= nextB;
      end
    end

    assign opsReady[i] = srcA[i].ready && srcB[i].ready;
  end

  aluOpE             pickOp;
  logic [DATA_W-1:0] pickA;
  logic [DATA_W-1:0] pickB;
  logic [TAG_W-1:0]  pickDst;

  always_comb begin
    pickOp  = OP_ADD;
    pickA   = '0;
    pickB   = '0;
    pickDst = '0;
    for (int i = 0; i < RS_DEPTH; i++) begin
      if (strb.issue[i]) begin
        pickOp  = slotOp[i];
        pickA   = srcA[i].value;
        pickB   = srcB[i].value;
        pickDst = slotDst[i];
      end
    end
  end

  aluOpE             s1Op;
  logic [DATA_W-1:0] s1A;
  logic [DATA_W-1:0] s1B;
  logic [TAG_W-1:0]  s1Dst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Op     <= OP_ADD;
      s1A      <= '0;
      s1B      <= '0;
      s1Dst    <= '0;
      resTag   <= '0;
      resValue <= '0;
    end else begin
      if (strb.fire) begin
        s1Op  <= pickOp;
        s1A   <= pickA;
        s1B   <= pickB;
        s1Dst <= pickDst;
      end
      resTag   <= s1Dst;
      resValue <= aluCompute(s1Op, s1A, s1B);
    end
  end

endmodule

// File: rtl/alu_issue_unit.sv
module alu_issue_unit
  import alu_rs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [OP_W-1:0]   dispOp,
  input  logic              dispAReady,
  input  logic [TAG_W-1:0]  dispATag,
  input  logic [DATA_W-1:0] dispAValue,
  input  logic              dispBReady,
  input  logic [TAG_W-1:0]  dispBTag,
  input  logic [DATA_W-1:0] dispBValue,
  input  logic [TAG_W-1:0]  dispDstTag,
  output logic              rsFull,
  input  logic              extValid,
  input  logic [TAG_W-1:0]  extTag,
  input  logic [DATA_W-1:0] extValue,
  output logic              resValid,
  output logic [TAG_W-1:0]  resTag,
  output logic [DATA_W-1:0] resValue
);

  rsStrobesT           strb;
  logic [RS_DEPTH-1:0] opsReady;
  operandT             dispA;
  operandT             dispB;

  assign dispA = '{value: dispAValue, tag: dispATag, ready: dispAReady};
  assign dispB = '{value: dispBValue, tag: dispBTag, ready: dispBReady};

  alu_rs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .dispValid(dispValid),
    .opsReady (opsReady),
    .strb     (strb),
    .rsFull   (rsFull),
    .resValid (resValid)
  );

  alu_rs_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dispOp    (dispOp),
    .dispA     (dispA),
    .dispB     (dispB),
    .dispDstTag(dispDstTag),
    .extValid  (extValid),
    .extTag    (extTag),
    .extValue  (extValue),
    .opsReady  (opsReady),
    .resTag    (resTag),
    .resValue  (resValue)
  );

endmodule

// File: rtl/alu_rs_checker.sv
module alu_rs_checker
  import alu_rs_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                dispValid,
  input logic                rsFull,
  input logic                resValid,
  input logic [RS_DEPTH-1:0] issueVec,
  input logic [RS_DEPTH-1:0] allocVec
);

  logic fire;
  assign fire = |issueVec;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!rsFull && !resValid));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    resValid == $past(fire, 2));

  p_pulse_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(issueVec));

  p_full_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rsFull) |-> $past(dispValid));

  p_single_fill_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(allocVec));

  p_no_fill_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    rsFull |=> !$past(|allocVec));

endmodule

bind alu_issue_unit alu_rs_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .dispValid(dispValid),
  .rsFull   (rsFull),
  .resValid (resValid),
  .issueVec (strb.issue),
  .allocVec (strb.alloc)
);

// File: tb/tb_alu_issue_unit.sv
module tb_alu_issue_unit;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dispValid = 1'b0;
  logic [2:0] dispOp = '0;
  logic       dispAReady = 1'b0;
  logic [1:0] dispATag = '0;
  logic [7:0] dispAValue = '0;
  logic       dispBReady = 1'b0;
  logic [1:0] dispBTag = '0;
  logic [7:0] dispBValue = '0;
  logic [1:0] dispDstTag = '0;
  logic       rsFull;
  logic       extValid = 1'b0;
  logic [1:0] extTag = '0;
  logic [7:0] extValue = '0;
  logic       resValid;
  logic [1:0] resTag;
  logic [7:0] resValue;

  int checks = 0;
  int errors = 0;
  bit started = 0;

  always #4 clk = ~clk;

  alu_issue_unit dut (.*);

  // ---------------- behavioural reference model ----------------
  int mV[2], mOp[2], mA[2], mAR[2], mAT[2], mB[2], mBR[2], mBT[2], mDst[2];
  int p1V, p1Op, p1A, p1B, p1T;
  int mOV, mOT, mOD;

  function automatic int refAlu(int op, int a, int b);
    case (op)
      0: return (a + b) & 255;
      1: return (a - b + 256) & 255;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return 0;
    endcase
  endfunction

  task automatic wake(inout int r, input int t, inout int v, input int ov, input int ot,
                      input int od);
    if (r == 0) begin
      if (ov != 0 && ot == t) begin v = od; r = 1; end
      else if (extValid && int'(extTag) == t) begin v = int'(extValue); r = 1; end
    end
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) mV[i] = 0;
      p1V = 0; mOV = 0; mOT = 0; mOD = 0;
    end else begin
      int ovS, otS, odS, sel, alc;
      ovS = mOV; otS = mOT; odS = mOD;
      mOV = p1V; mOT = p1T; mOD = refAlu(p1Op, p1A, p1B);
      sel = -1;
      for (int i = 0; i < 2; i++)
        if (sel < 0 && mV[i] != 0 && mAR[i] != 0 && mBR[i] != 0) sel = i;
      alc = -1;
      if (dispValid && !(mV[0] != 0 && mV[1] != 0))
        for (int i = 0; i < 2; i++) if (alc < 0 && mV[i] == 0) alc = i;
      p1V = (sel >= 0) ? 1 : 0;
      if (sel >= 0) begin
        p1Op = mOp[sel]; p1A = mA[sel]; p1B = mB[sel]; p1T = mDst[sel];
        mV[sel] = 0;
      end
      for (int i = 0; i < 2; i++) begin
        wake(mAR[i], mAT[i], mA[i], ovS, otS, odS);
        wake(mBR[i], mBT[i], mB[i], ovS, otS, odS);
      end
      if (alc >= 0) begin
        mV[alc] = 1; mOp[alc] = int'(dispOp); mDst[alc] = int'(dispDstTag);
        mAR[alc] = int'(dispAReady); mAT[alc] = int'(dispATag); mA[alc] = int'(dispAValue);
        mBR[alc] = int'(dispBReady); mBT[alc] = int'(dispBTag); mB[alc] = int'(dispBValue);
        wake(mAR[alc], mAT[alc], mA[alc], ovS, otS, odS);
        wake(mBR[alc], mBT[alc], mB[alc], ovS, otS, odS);
      end
    end
  end

  always @(negedge clk) begin
    if (started && rstN) begin
      checks++;
      if (int'(rsFull) != ((mV[0] != 0 && mV[1] != 0) ? 1 : 0)) begin
        errors++;
        $display("FAIL R7 model rsFull: got %0d expected %0d", rsFull, mV[0] != 0 && mV[1] != 0);
      end
      checks++;
      if (int'(resValid) != mOV) begin
        errors++;
        $display("FAIL R3 model resValid: got %0d expected %0d", resValid, mOV);
      end else if (mOV != 0 && (int'(resTag) != mOT || int'(resValue) != mOD)) begin
        errors++;
        $display("FAIL R2 model result: got tag %0d val %0d expected tag %0d val %0d",
                 resTag, resValue, mOT, mOD);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic stp();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chkRes(input string req, input int tag, input int val);
    chk(resValid == 1'b1, req, resValid, 1);
    chk(int'(resTag) == tag, req, resTag, tag);
    chk(int'(resValue) == val, req, resValue, val);
  endtask

  task automatic chkIdle(input string req);
    chk(resValid == 1'b0, req, resValid, 0);
  endtask

  task automatic disp(input int op, input bit ar, input int at, input int av,
                      input bit br, input int bt, input int bv, input int dst);
    dispValid = 1'b1; dispOp = 3'(op);
    dispAReady = ar; dispATag = 2'(at); dispAValue = 8'(av);
    dispBReady = br; dispBTag = 2'(bt); dispBValue = 8'(bv);
    dispDstTag = 2'(dst);
  endtask

  task automatic idle();
    dispValid = 1'b0;
  endtask

  task automatic bcast(input int t, input int v);
    extValid = 1'b1; extTag = 2'(t); extValue = 8'(v);
  endtask

  task automatic bcastOff();
    extValid = 1'b0;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    int expOp[5];
    expOp = '{8'h8F, 8'hDB, 8'h10, 8'h7F, 8'h6F};
    stp(); stp();
    rstN = 1'b1;
    started = 1;
    stp();
    chk(rsFull == 1'b0, "R1 rsFull after reset", rsFull, 0);
    chkIdle("R1 resValid after reset");

    // R2 / R3: every opcode, fixed latency, single-cycle pulse
    for (int op = 0; op < 5; op++) begin
      disp(op, 1, 0, 8'h35, 1, 0, 8'h5A, op % 4);
      stp(); idle(); stp();
      chkIdle("R3 no result before third cycle");
      stp();
      chkRes("R2 opcode result", op % 4, expOp[op]);
      stp();
      chkIdle("R3 one-cycle pulse");
    end
    disp(0, 1, 0, 8'hC8, 1, 0, 8'h64, 3);
    stp(); idle(); stp(); stp();
    chkRes("R2 add wraps", 3, 8'h2C);
    stp();

    // R4: wakeup from external broadcast
    disp(0, 1, 0, 7, 0, 2, 0, 3);
    stp(); idle(); stp(); stp(); stp();
    chkIdle("R4 waits for source");
    bcast(2, 10);
    stp(); bcastOff(); stp();
    chkIdle("R4 not early");
    stp();
    chkRes("R4 woken result", 3, 17);
    stp();

    // R6: broadcast in the dispatch cycle
    disp(1, 1, 0, 3, 0, 1, 0, 0);
    bcast(1, 5);
    stp(); idle(); bcastOff(); stp(); stp();
    chkRes("R6 same-cycle capture", 0, 8'hFE);
    stp();

    // R5: dependent on own result
    disp(0, 1, 0, 1, 1, 0, 2, 0);
    stp();
    disp(4, 0, 0, 0, 1, 0, 8'h0F, 1);
    stp(); idle(); stp();
    chkRes("R5 producer", 0, 3);
    stp(); chkIdle("R5 gap");
    stp(); chkIdle("R5 gap");
    stp();
    chkRes("R5 dependent", 1, 8'h0C);
    stp();

    // R7 / R8: full flag, ignored dispatch, younger ready goes first
    disp(0, 0, 2, 0, 1, 0, 1, 0);
    stp();
    disp(3, 1, 0, 8'h0F, 1, 0, 8'hF0, 1);
    stp();
    chk(rsFull == 1'b1, "R7 full with two slots", rsFull, 1);
    disp(2, 1, 0, 8'hFF, 1, 0, 8'hFF, 2);
    stp(); idle();
    chk(rsFull == 1'b0, "R7 slot freed on issue", rsFull, 0);
    stp();
    chkRes("R8 younger ready first", 1, 8'hFF);
    bcast(2, 9);
    stp(); bcastOff(); stp(); stp();
    chkRes("R8 older after wakeup", 0, 10);
    for (int k = 0; k < 4; k++) begin
      stp();
      chkIdle("R7 dispatch while full ignored");
    end

    // R9 / R10: slot order and consecutive results
    disp(0, 1, 0, 1, 1, 0, 1, 0);
    stp();
    disp(0, 0, 3, 0, 1, 0, 8'h10, 1);
    stp();
    disp(3, 0, 3, 0, 1, 0, 8'h20, 2);
    stp(); idle();
    chkRes("R3 first op", 0, 2);
    bcast(3, 1);
    stp(); bcastOff(); stp();
    chkIdle("R9 not yet");
    stp();
    chkRes("R9 lower slot first", 2, 8'h21);
    stp();
    chkRes("R10 next cycle result", 1, 8'h11);
    stp();
    chkIdle("R10 pipeline empty");

    // random stream, compared with the model every cycle
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) != 0)
        disp($urandom_range(0, 4), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
             $urandom_range(0, 255), 1'($urandom_range(0, 1)), $urandom_range(0, 3),
             $urandom_range(0, 255), $urandom_range(0, 3));
      else idle();
      if ($urandom_range(0, 2) == 0) bcast($urandom_range(0, 3), $urandom_range(0, 255));
      else bcastOff();
      stp();
    end
    idle(); bcastOff();
    for (int k = 0; k < 8; k++) bcast(k % 4, k);
    stp(); bcastOff();
    repeat (20) stp();
    finishRun();
  end

endmodule